// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a clocked system and an external asynchronous static RAM of 8192 bytes. A client presents one request at a time on a valid/ready handshake: a 13-bit address, a byte of write data and a write flag. The sequencer turns each request into a correctly spaced sequence on the memory pins. These are two select lines of opposite polarity, an active-low write strobe, an active-low read enable, the address bus, and a split data path with a drive enable for the external tri-state pad. For a read it returns the byte with a single-cycle valid pulse.

Every analogue timing value is a parameter in nanoseconds, together with the clock period. The block rounds each value up to whole clock cycles, with a floor of one cycle per phase. An access runs through an address-setup phase with all strobes idle, an active phase (read or write), and for writes a data-hold phase. Between accesses the sequencer returns to a fully deselected idle state. A build option keeps the read enable low through writes. In that option the write pulse is lengthened so the memory's output drivers turn off before the sequencer starts driving data.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is asserted and after it, until a request arrives: mem_en_n=1, mem_en=0, mem_wr_n=1, mem_rd_n=1, mem_drive=0, rsp_valid=0, and req_ready=1 once reset has been released.
- R2: mem_addr changes only between two cycles in which mem_en_n=1, mem_en=0 and mem_wr_n=1.
- R3: mem_wr_n or mem_rd_n is low only in cycles where the memory is selected, that is mem_en_n=0 and mem_en=1 together.
- R4: A read holds the memory selected with mem_rd_n=0 and mem_wr_n=1 for max(cyc(tAA), cyc(tOE), cyc(tRC)) cycles, after a setup phase of cyc(tAS) cycles. The byte on mem_rdata at the last read cycle is returned on rsp_rdata. Here cyc(t) is t divided by the clock period, rounded up, and never less than 1.
- R5: mem_drive is never high in a cycle where the memory is selected with mem_rd_n=0 and mem_wr_n=1. It is low in the cycle before any such read cycle.
- R6: With OE_LOW_IN_WRITE=0 the write strobe (memory selected and mem_wr_n=0) lasts exactly max(cyc(tWP), cyc(tCW), cyc(tDW)) cycles with mem_rd_n=1. Write data is driven throughout the pulse.
- R7: With OE_LOW_IN_WRITE=1 the write pulse lasts max(R6 value, cyc(tWHZ)+cyc(tDW)) cycles. Data is driven only in its last (pulse - cyc(tWHZ)) cycles.
- R8: After the write pulse all strobes go inactive and mem_drive stays high for max(cyc(tDH), cyc(tWC) - setup - pulse) cycles. Then it is released.
- R9: A request is accepted on a clock edge with req_valid=1 and req_ready=1. req_ready is low from the next cycle until the access completes. The total latency is setup+read cycles for a read and setup+pulse+hold cycles for a write.
- R10: rsp_valid is high for exactly one cycle, the cycle after the last read cycle, and never for a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write byte |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | DATA_W | Read byte |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_en_n | output | 1 | Active-low select |
| mem_en | output | 1 | Active-high select |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_rd_n | output | 1 | Active-low output enable of the memory |
| mem_wdata | output | DATA_W | Data toward the pad |
| mem_drive | output | 1 | Pad drive enable |
| mem_rdata | input | DATA_W | Data from the pad |

## Verification
Assertions check the pin rules on every cycle. These are: the address is quiet around any strobe, the strobes occur only inside a full select, there is no overlap of pad drive and memory read-out, the bus is released before a read, hold-phase driving happens only with strobes off, and the response pulse lasts a single cycle. Pulse lengths, hold lengths, latencies and returned data can only be shown by the bench's scenarios. In those scenarios, a cycle-sampled memory model stores bytes at the end of each write strobe and returns garbage unless access and enable times have elapsed. The bench sweeps 64 addresses, including both ends of the space, in both the default build and the read-enable-held build.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_RD    = 3'd2,
    ST_WR    = 3'd3,
    ST_HOLD  = 3'd4
  } sramc_state_e;

  // nanoseconds to clock cycles, rounded up, at least one cycle
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sramc_timer.sv
module sramc_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_d,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
    else
      cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/sramc_seq.sv
module sramc_seq
  import sramc_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int AS_C  = 1,
  parameter int RD_C  = 1,
  parameter int WP_C  = 1,
  parameter int DH_C  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             timer_done,
  output sramc_state_e     state_q,
  output sramc_state_e     state_d,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             req_ready,
  output logic             accept,
  output logic             capture
);

  logic is_wr_q;

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_val = '0;
    accept   = 1'b0;
    capture  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept   = 1'b1;
          state_d  = ST_SETUP;
          load     = 1'b1;
          load_val = CNT_W'(AS_C - 1);
        end
      end
      ST_SETUP: begin
        if (timer_done) begin
          load = 1'b1;
          if (is_wr_q) begin
            state_d  = ST_WR;
            load_val = CNT_W'(WP_C - 1);
          end else begin
            state_d  = ST_RD;
            load_val = CNT_W'(RD_C - 1);
          end
        end
      end
      ST_RD: begin
        if (timer_done) begin
          capture = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_WR: begin
        if (timer_done) begin
          state_d  = ST_HOLD;
          load     = 1'b1;
          load_val = CNT_W'(DH_C - 1);
        end
      end
      ST_HOLD: begin
        if (timer_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      is_wr_q <= 1'b0;
    else if (accept) is_wr_q <= req_write;
  end

  assign req_ready = (state_q == ST_IDLE);

  // R9: once a request is taken the sequencer reports busy
  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  // R9: no access phase is entered without an accepted request
  a_r9_setup_from_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SETUP && $past(state_q) == ST_IDLE) |-> $past(req_valid));

endmodule

// File: rtl/sramc_pins.sv
module sramc_pins
  import sramc_pkg::*;
#(
  parameter int ADDR_W          = 13,
  parameter int DATA_W          = 8,
  parameter int CNT_W           = 4,
  parameter int DRV_C           = 1,
  parameter int OE_LOW_IN_WRITE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  sramc_state_e      state_d,
  input  logic [CNT_W-1:0]  cnt_d,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_en_n,
  output logic              mem_en,
  output logic              mem_wr_n,
  output logic              mem_rd_n,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_drive,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  localparam logic [CNT_W-1:0] DRV_LIM = CNT_W'(DRV_C);

  logic rden_in_wr;
  logic sel_d, en_n_d, en_d, wr_n_d, rd_n_d, drive_d;

  generate
    if (OE_LOW_IN_WRITE != 0) begin : g_rden_held
      assign rden_in_wr = 1'b1;
    end else begin : g_rden_off
      assign rden_in_wr = 1'b0;
    end
  endgenerate

  always_comb begin
    sel_d   = (state_d == ST_RD) || (state_d == ST_WR);
    en_n_d  = !sel_d;
    en_d    = sel_d;
    wr_n_d  = (state_d != ST_WR);
    rd_n_d  = !((state_d == ST_RD) || (rden_in_wr && (state_d == ST_WR)));
    drive_d = ((state_d == ST_WR) && (cnt_d < DRV_LIM)) || (state_d == ST_HOLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_en_n  <= 1'b1;
      mem_en    <= 1'b0;
      mem_wr_n  <= 1'b1;
      mem_rd_n  <= 1'b1;
      mem_drive <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      mem_en_n  <= en_n_d;
      mem_en    <= en_d;
      mem_wr_n  <= wr_n_d;
      mem_rd_n  <= rd_n_d;
      mem_drive <= drive_d;
      rsp_valid <= capture;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (accept) begin
      mem_addr  <= req_addr;
      mem_wdata <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rsp_rdata <= '0;
    else if (capture) rsp_rdata <= mem_rdata;
  end

  // R2: address moves only with every strobe idle before and after the edge
  a_r2_addr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr != $past(mem_addr)) |->
      (mem_en_n && !mem_en && mem_wr_n && $past(mem_en_n && !mem_en && mem_wr_n)));

  // R3: write strobe only inside a full select
  a_r3_wr_in_select: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr_n |-> (!mem_en_n && mem_en));

  // R3: read enable only inside a full select
  a_r3_rd_in_select: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rd_n |-> (!mem_en_n && mem_en));

  // R5: pad never drives while the memory may drive
  a_r5_no_fight: assert property (@(posedge clk) disable iff (!rst_n)
    mem_drive |-> (mem_rd_n || !mem_wr_n));

  // R5: bus released at least one cycle before read-out
  a_r5_release_first: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_rd_n && mem_wr_n) |-> (!mem_drive && !$past(mem_drive)));

  // R8: hold driving happens with all strobes inactive
  a_r8_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_drive && mem_wr_n) |-> (mem_en_n && !mem_en && mem_rd_n));

  // R10: the response pulse is a single cycle
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sramc_pkg::*;
#(
  parameter int ADDR_W          = 13,
  parameter int DATA_W          = 8,
  parameter int CLK_NS          = 20,
  parameter int T_RC_NS         = 15,
  parameter int T_AA_NS         = 15,
  parameter int T_OE_NS         = 7,
  parameter int T_WC_NS         = 15,
  parameter int T_WP_NS         = 14,
  parameter int T_CW_NS         = 14,
  parameter int T_AS_NS         = 0,
  parameter int T_DW_NS         = 8,
  parameter int T_DH_NS         = 0,
  parameter int T_WHZ_NS        = 6,
  parameter int OE_LOW_IN_WRITE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_en_n,
  output logic              mem_en,
  output logic              mem_wr_n,
  output logic              mem_rd_n,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_drive,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam int AS_C    = ns_to_cyc(T_AS_NS, CLK_NS);
  localparam int RD_C    = imax(imax(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_OE_NS, CLK_NS)),
                                ns_to_cyc(T_RC_NS, CLK_NS));
  localparam int DW_C    = ns_to_cyc(T_DW_NS, CLK_NS);
  localparam int WP_BASE = imax(imax(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_CW_NS, CLK_NS)), DW_C);
  localparam int WHZ_C   = (OE_LOW_IN_WRITE != 0) ? ns_to_cyc(T_WHZ_NS, CLK_NS) : 0;
  localparam int WP_C    = (OE_LOW_IN_WRITE != 0) ? imax(WP_BASE, WHZ_C + DW_C) : WP_BASE;
  localparam int DRV_C   = WP_C - WHZ_C;
  localparam int WC_C    = ns_to_cyc(T_WC_NS, CLK_NS);
  localparam int DH_MIN  = ns_to_cyc(T_DH_NS, CLK_NS);
  localparam int DH_C    = (WC_C > AS_C + WP_C + DH_MIN) ? (WC_C - AS_C - WP_C) : DH_MIN;
  localparam int MAX_C   = imax(imax(AS_C, RD_C), imax(WP_C, DH_C));
  localparam int CNT_W   = $clog2(MAX_C + 1);

  logic [1:0]       rst_sync;
  logic             rst_i;
  sramc_state_e     state_q, state_d;
  logic             load, done, accept, capture;
  logic [CNT_W-1:0] load_val, cnt_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  sramc_seq #(
    .CNT_W(CNT_W), .AS_C(AS_C), .RD_C(RD_C), .WP_C(WP_C), .DH_C(DH_C)
  ) i_seq (
    .clk        (clk),
    .rst_n      (rst_i),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .timer_done (done),
    .state_q    (state_q),
    .state_d    (state_d),
    .load       (load),
    .load_val   (load_val),
    .req_ready  (req_ready),
    .accept     (accept),
    .capture    (capture)
  );

  sramc_timer #(.CNT_W(CNT_W)) i_timer (
    .clk      (clk),
    .rst_n    (rst_i),
    .load     (load),
    .load_val (load_val),
    .cnt_d    (cnt_d),
    .done     (done)
  );

  sramc_pins #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .DRV_C(DRV_C),
    .OE_LOW_IN_WRITE(OE_LOW_IN_WRITE)
  ) i_pins (
    .clk       (clk),
    .rst_n     (rst_i),
    .accept    (accept),
    .capture   (capture),
    .state_d   (state_d),
    .cnt_d     (cnt_d),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_en_n  (mem_en_n),
    .mem_en    (mem_en),
    .mem_wr_n  (mem_wr_n),
    .mem_rd_n  (mem_rd_n),
    .mem_wdata (mem_wdata),
    .mem_drive (mem_drive),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

endmodule

// File: tb/test_sram_ctrl.sv
module sram_model #(
  parameter int AA_C = 1,
  parameter int OE_C = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [12:0] addr,
  input  logic        en_n,
  input  logic        en,
  input  logic        wr_n,
  input  logic        rd_n,
  input  logic        drive,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  output int          pulse_len,
  output int          drv_len,
  output int          hold_len,
  output int          bad_addr,
  output int          bad_sel,
  output int          bad_fight
);
  logic [7:0] mem [int];

  initial begin
    int cur_p, cur_d, hc, oe_c, ad_c;
    logic [12:0] p_addr;
    logic p_strobe, p_wcyc, sel, wcyc, strobe;
    logic [7:0] last_w;
    cur_p = 0; cur_d = 0; hc = 0; oe_c = 0; ad_c = 0;
    p_addr = '0; p_strobe = 1'b0; p_wcyc = 1'b0; last_w = '0;
    pulse_len = 0; drv_len = 0; hold_len = 0;
    bad_addr = 0; bad_sel = 0; bad_fight = 0; rdata = 8'hEE;
    forever begin
      @(posedge clk);
      #5;
      sel    = !en_n && en;
      wcyc   = sel && !wr_n;
      strobe = !en_n || en || !wr_n;
      if (rst_n) begin
        if (addr != p_addr && (strobe || p_strobe)) bad_addr++;
        if ((!wr_n || !rd_n) && !sel) bad_sel++;
        if (drive && sel && wr_n && !rd_n) bad_fight++;
      end
      if (wcyc) begin
        cur_p++;
        if (drive) begin cur_d++; last_w = wdata; end
      end else begin
        if (p_wcyc) begin
          pulse_len = cur_p; drv_len = cur_d;
          mem[int'(p_addr)] = last_w;
          cur_p = 0; cur_d = 0;
          hc = drive ? 1 : 0;
        end else if (drive) hc++;
        hold_len = hc;
      end
      if (sel && wr_n && !rd_n) oe_c++; else oe_c = 0;
      if (addr == p_addr) ad_c++; else ad_c = 1;
      if (sel && wr_n && !rd_n && oe_c >= OE_C && ad_c >= AA_C)
        rdata = mem.exists(int'(addr)) ? mem[int'(addr)] : 8'h00;
      else
        rdata = 8'hEE;
      p_addr = addr; p_strobe = strobe; p_wcyc = wcyc;
    end
  end
endmodule

module test_sram_ctrl;
  localparam int CLK  = 20;
  localparam int RC = 55, AA = 55, OE = 25, WC = 120, WP = 45, CW = 50;
  localparam int AS = 0, DW = 25, DH = 5, WHZ = 30;

  function automatic int cyc(input int ns);
    int c; c = (ns + CLK - 1) / CLK; return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;

  logic        a_valid = 0, a_write = 0, b_valid = 0, b_write = 0;
  logic [12:0] a_addr = '0, b_addr = '0;
  logic [7:0]  a_wd = '0, b_wd = '0;
  logic        a_ready, a_rv, a_en_n, a_en, a_wr_n, a_rd_n, a_drive;
  logic        b_ready, b_rv, b_en_n, b_en, b_wr_n, b_rd_n, b_drive;
  logic [7:0]  a_rdata, a_mwd, a_mrd, b_rdata, b_mwd, b_mrd;
  logic [12:0] a_maddr, b_maddr;
  int a_pl, a_dl, a_hl, a_ba, a_bs, a_bf;
  int b_pl, b_dl, b_hl, b_ba, b_bs, b_bf;

  sram_ctrl #(.CLK_NS(CLK), .T_RC_NS(RC), .T_AA_NS(AA), .T_OE_NS(OE), .T_WC_NS(WC),
    .T_WP_NS(WP), .T_CW_NS(CW), .T_AS_NS(AS), .T_DW_NS(DW), .T_DH_NS(DH),
    .T_WHZ_NS(WHZ), .OE_LOW_IN_WRITE(0)) i_sram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(a_valid), .req_ready(a_ready),
    .req_write(a_write), .req_addr(a_addr), .req_wdata(a_wd), .rsp_valid(a_rv),
    .rsp_rdata(a_rdata), .mem_addr(a_maddr), .mem_en_n(a_en_n), .mem_en(a_en),
    .mem_wr_n(a_wr_n), .mem_rd_n(a_rd_n), .mem_wdata(a_mwd), .mem_drive(a_drive),
    .mem_rdata(a_mrd));

  sram_ctrl #(.CLK_NS(CLK), .T_RC_NS(RC), .T_AA_NS(AA), .T_OE_NS(OE), .T_WC_NS(WC),
    .T_WP_NS(WP), .T_CW_NS(CW), .T_AS_NS(AS), .T_DW_NS(DW), .T_DH_NS(DH),
    .T_WHZ_NS(WHZ), .OE_LOW_IN_WRITE(1)) i_sram_ctrl_rden (
    .clk(clk), .rst_n(rst_n), .req_valid(b_valid), .req_ready(b_ready),
    .req_write(b_write), .req_addr(b_addr), .req_wdata(b_wd), .rsp_valid(b_rv),
    .rsp_rdata(b_rdata), .mem_addr(b_maddr), .mem_en_n(b_en_n), .mem_en(b_en),
    .mem_wr_n(b_wr_n), .mem_rd_n(b_rd_n), .mem_wdata(b_mwd), .mem_drive(b_drive),
    .mem_rdata(b_mrd));

  sram_model #(.AA_C(3), .OE_C(2)) i_model_a (
    .clk(clk), .rst_n(rst_n), .addr(a_maddr), .en_n(a_en_n), .en(a_en), .wr_n(a_wr_n),
    .rd_n(a_rd_n), .drive(a_drive), .wdata(a_mwd), .rdata(a_mrd), .pulse_len(a_pl),
    .drv_len(a_dl), .hold_len(a_hl), .bad_addr(a_ba), .bad_sel(a_bs), .bad_fight(a_bf));

  sram_model #(.AA_C(3), .OE_C(2)) i_model_b (
    .clk(clk), .rst_n(rst_n), .addr(b_maddr), .en_n(b_en_n), .en(b_en), .wr_n(b_wr_n),
    .rd_n(b_rd_n), .drive(b_drive), .wdata(b_mwd), .rdata(b_mrd), .pulse_len(b_pl),
    .drv_len(b_dl), .hold_len(b_hl), .bad_addr(b_ba), .bad_sel(b_bs), .bad_fight(b_bf));

  // expected cycle counts derived from the requirements
  localparam int AS_E  = 1;
  int rd_e, wp_a, wp_b, drv_b, dh_a, dh_b;

  task automatic chk(input string r, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  function automatic logic [12:0] adr(input int i);
    if (i == 0)  return 13'h0000;
    if (i == 63) return 13'h1FFF;
    return 13'(i * 127);
  endfunction
  function automatic logic [7:0] dat(input int i, input int p);
    logic [7:0] v;
    v = 8'(i * 37 + 5 + p * 91);
    return (p == 1) ? ~v : v;
  endfunction

  // called at a falling edge with the selected unit idle; returns at a falling edge
  task automatic xfer(input int u, input bit wr, input logic [12:0] ad,
                      input logic [7:0] wd, input logic [7:0] exp_rd);
    int n, exp_lat;
    logic ry, rv;
    logic [7:0] rdv;
    ry = (u == 0) ? a_ready : b_ready;
    chk("R9 ready before request", int'(ry), 1);
    if (u == 0) begin a_valid = 1; a_write = wr; a_addr = ad; a_wd = wd; end
    else        begin b_valid = 1; b_write = wr; b_addr = ad; b_wd = wd; end
    @(posedge clk);
    @(negedge clk);
    a_valid = 0; b_valid = 0;
    ry = (u == 0) ? a_ready : b_ready;
    rv = (u == 0) ? a_rv : b_rv;
    chk("R9 ready low after accept", int'(ry), 0);
    chk("R10 previous pulse ended", int'(rv), 0);
    n = 0;
    while (!ry && n < 64) begin
      @(posedge clk); n++;
      @(negedge clk);
      ry = (u == 0) ? a_ready : b_ready;
    end
    rv  = (u == 0) ? a_rv : b_rv;
    rdv = (u == 0) ? a_rdata : b_rdata;
    if (wr) begin
      exp_lat = AS_E + ((u == 0) ? (wp_a + dh_a) : (wp_b + dh_b));
      chk("R9 write latency", n, exp_lat);
      chk("R10 no pulse on write", int'(rv), 0);
      if (u == 0) begin
        chk("R6 pulse length", a_pl, wp_a);
        chk("R6 data over whole pulse", a_dl, wp_a);
        chk("R8 hold length", a_hl, dh_a);
      end else begin
        chk("R7 stretched pulse", b_pl, wp_b);
        chk("R7 drive window", b_dl, drv_b);
        chk("R8 hold length held-enable build", b_hl, dh_b);
      end
    end else begin
      chk("R9 read latency", n, AS_E + rd_e);
      chk("R10 read pulse", int'(rv), 1);
      chk("R4 read data", int'(rdv), int'(exp_rd));
    end
  endtask

  initial begin
    rd_e  = mx(mx(cyc(AA), cyc(OE)), cyc(RC));
    wp_a  = mx(mx(cyc(WP), cyc(CW)), cyc(DW));
    wp_b  = mx(wp_a, cyc(WHZ) + cyc(DW));
    drv_b = wp_b - cyc(WHZ);
    dh_a  = mx(cyc(DH), cyc(WC) - AS_E - wp_a);
    dh_b  = mx(cyc(DH), cyc(WC) - AS_E - wp_b);

    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 select low side", int'(a_en_n), 1);
    chk("R1 select high side", int'(a_en), 0);
    chk("R1 write strobe", int'(a_wr_n), 1);
    chk("R1 read enable", int'(a_rd_n), 1);
    chk("R1 pad drive", int'(a_drive), 0);
    chk("R1 response", int'(a_rv), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 ready after reset", int'(a_ready), 1);
    chk("R1 strobes idle after reset", int'(a_en_n & ~a_en & a_wr_n & a_rd_n & ~a_drive), 1);

    for (int i = 0; i < 64; i++) xfer(0, 1'b1, adr(i), dat(i, 0), 8'h00);
    for (int i = 0; i < 64; i++) xfer(0, 1'b0, adr(i), 8'h00, dat(i, 0));
    for (int i = 0; i < 64; i += 2) begin
      xfer(0, 1'b1, adr(i), dat(i, 1), 8'h00);
      xfer(0, 1'b0, adr(i), 8'h00, dat(i, 1));
    end
    for (int i = 1; i < 64; i += 2) xfer(0, 1'b0, adr(i), 8'h00, dat(i, 0));

    for (int i = 0; i < 64; i += 4) begin
      xfer(1, 1'b1, adr(i), dat(i, 2), 8'h00);
      xfer(1, 1'b0, adr(i), 8'h00, dat(i, 2));
    end
    for (int i = 0; i < 64; i += 4) xfer(1, 1'b0, adr(i), 8'h00, dat(i, 2));

    repeat (3) @(negedge clk);
    chk("R2 address quiet around strobes", a_ba + b_ba, 0);
    chk("R3 strobes inside select", a_bs + b_bs, 0);
    chk("R5 no bus fight", a_bf + b_bf, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule